// File: doc/BRIEF.md
# Video Sync and NMI Timing Generator

This block builds the display timing for a small home computer with an 8-bit CPU, using one fast dot clock. It halves the dot clock to make the CPU clock. It counts CPU clock periods to form horizontal lines and counts lines to form frames. From those counts it drives an active-low line sync, an active-low frame sync and an active-low composite sync that combines them.

Software on the CPU can rebuild the picture on each line by way of a non-maskable interrupt. The interrupt request is timed to the line sync and is gated by an enable input. While the request is low and the CPU is running, so that its halt line is high, the block pulls the CPU's WAIT line low. This stretches the interrupt entry so that it ends in step with the sync pulse. A halted CPU is not held.

All counters and outputs are registered on the dot clock and are cleared by a synchronous active-high reset. No output can therefore glitch. The default parameters give a 207-cycle line, a 19-cycle line sync, 262 lines per frame and a 1212-cycle frame sync.

Top module: `video_sync_gen`

## Requirements
- R1: `cpu_clk` has a period of `CLK_DIV` dot clocks and is high for `CLK_DIV/2` of them.
- R2: `hsync_n` falls once every `LINE_CYCLES*CLK_DIV` dot clocks and stays low for `HSYNC_CYCLES*CLK_DIV` dot clocks.
- R3: `vsync_n` falls once every `LINE_CYCLES*FRAME_LINES*CLK_DIV` dot clocks and stays low for `VSYNC_CYCLES*CLK_DIV` dot clocks. It falls on the same dot clock as the first line sync of the frame, so its width is counted in CPU cycles and not in whole lines.
- R4: `csync_n` is low exactly when `hsync_n` or `vsync_n` is low.
- R5: While `nmi_en` is high, `nmi_n` follows `hsync_n` exactly. While `nmi_en` is low, `nmi_n` stays high. A change on `nmi_en` reaches `nmi_n` one dot clock later.
- R6: `wait_n` is low exactly when `nmi_n` is low and `halt_n` is high. A change on `halt_n` reaches `wait_n` one dot clock later, and `wait_n` rises on the same dot clock as `nmi_n`.
- R7: While `halt_n` is low, `wait_n` stays high, even through a full NMI pulse.
- R8: While `rst` is high on a dot clock edge, all active-low outputs are high and `cpu_clk` is low. The first edge after `rst` falls drives `hsync_n` and `vsync_n` low, because line 0, cycle 0 starts there. `cpu_clk` is low on that edge and rises on the next one.
- R9: Every active-low output changes only on a dot clock edge on which `cpu_clk` goes low or stays low, which is the start of a CPU period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| halt_n | input | 1 | CPU halt status, low when halted |
| nmi_en | input | 1 | Enables NMI generation, high to enable |
| cpu_clk | output | 1 | CPU clock, dot clock divided by `CLK_DIV` |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |
| wait_n | output | 1 | CPU wait request, active low |

## Verification
Every output is one register stage away from its inputs. A change on `halt_n` or `nmi_en` therefore shows up one dot clock later. The first sync edges appear one dot clock after `rst` is released, and each counter state then holds for `CLK_DIV` dot clocks. The bench drives its inputs on the falling edge of the dot clock and samples on later falling edges: one edge after a stimulus for the reset and `halt_n` cases, and on every edge when it measures widths and periods. Widths and periods are counted in falling-edge samples between transitions, so the expected values are exact products of the parameters. The bench uses short lines and frames, so several complete frames fit into one run.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    // Internal active-high view of the registered timing outputs.
    typedef struct packed {
        logic line_sync;
        logic frame_sync;
        logic comp_sync;
        logic irq;
        logic hold;
    } vsg_flags_t;

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vsg_clkdiv.sv
module vsg_clkdiv #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic cpu_clk
);
    import vsg_pkg::*;

    localparam int PH_W = cnt_bits(CLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(CLK_DIV / 2);

    generate
        if (CLK_DIV == 2) begin : g_toggle
            logic phase;
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase   <= 1'b0;
                    cpu_clk <= 1'b0;
                end else begin
                    phase   <= ~phase;
                    cpu_clk <= phase;
                end
            end
            assign tick = phase;
        end else begin : g_count
            logic [PH_W-1:0] phase;
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase   <= '0;
                    cpu_clk <= 1'b0;
                end else begin
                    phase   <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                    cpu_clk <= (phase >= PH_HIGH);
                end
            end
            assign tick = (phase == PH_LAST);
        end
    endgenerate

endmodule

// File: rtl/vsg_timebase.sv
module vsg_timebase #(
    parameter int LINE_CYCLES  = 207,
    parameter int HSYNC_CYCLES = 19,
    parameter int FRAME_LINES  = 262,
    parameter int VSYNC_CYCLES = 1212
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic line_act,
    output logic frame_act
);
    import vsg_pkg::*;

    localparam int CYC_W = cnt_bits(LINE_CYCLES);
    localparam int LN_W  = cnt_bits(FRAME_LINES);
    localparam int VS_W  = cnt_bits(VSYNC_CYCLES + 1);

    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(LINE_CYCLES - 1);
    localparam logic [CYC_W-1:0] HS_END   = CYC_W'(HSYNC_CYCLES);
    localparam logic [LN_W-1:0]  LN_LAST  = LN_W'(FRAME_LINES - 1);
    localparam logic [VS_W-1:0]  VS_LOAD  = VS_W'(VSYNC_CYCLES);

    logic [CYC_W-1:0] cyc;
    logic [LN_W-1:0]  line;
    logic [VS_W-1:0]  vs_left;
    logic             line_wrap;
    logic             frame_wrap;

    assign line_wrap  = (cyc == CYC_LAST);
    assign frame_wrap = line_wrap && (line == LN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            line <= '0;
        end else if (tick) begin
            if (line_wrap) begin
                cyc  <= '0;
                line <= frame_wrap ? '0 : line + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // Frame sync: remaining CPU cycles of the pulse, reloaded at frame start.
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_left <= VS_LOAD;
        end else if (tick) begin
            if (frame_wrap) begin
                vs_left <= VS_LOAD;
            end else if (vs_left != '0) begin
                vs_left <= vs_left - 1'b1;
            end
        end
    end

    assign line_act  = (cyc < HS_END);
    assign frame_act = (vs_left != '0);

endmodule

// File: rtl/vsg_outreg.sv
module vsg_outreg (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_act,
    input  logic                frame_act,
    input  logic                nmi_en,
    input  logic                halt_n,
    output vsg_pkg::vsg_flags_t flags
);
    import vsg_pkg::*;

    vsg_flags_t nxt;

    always_comb begin
        nxt.line_sync  = line_act;
        nxt.frame_sync = frame_act;
        nxt.comp_sync  = line_act | frame_act;
        nxt.irq        = line_act & nmi_en;
        nxt.hold       = line_act & nmi_en & halt_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= nxt;
        end
    end

endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
    parameter int CLK_DIV      = 2,
    parameter int LINE_CYCLES  = 207,
    parameter int HSYNC_CYCLES = 19,
    parameter int FRAME_LINES  = 262,
    parameter int VSYNC_CYCLES = 1212
) (
    input  logic clk,
    input  logic rst,
    input  logic halt_n,
    input  logic nmi_en,
    output logic cpu_clk,
    output logic hsync_n,
    output logic vsync_n,
    output logic csync_n,
    output logic nmi_n,
    output logic wait_n
);
    import vsg_pkg::*;

    logic       tick;
    logic       line_act;
    logic       frame_act;
    vsg_flags_t flags;

    vsg_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cpu_clk (cpu_clk)
    );

    vsg_timebase #(
        .LINE_CYCLES  (LINE_CYCLES),
        .HSYNC_CYCLES (HSYNC_CYCLES),
        .FRAME_LINES  (FRAME_LINES),
        .VSYNC_CYCLES (VSYNC_CYCLES)
    ) u_tb (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line_act  (line_act),
        .frame_act (frame_act)
    );

    vsg_outreg u_out (
        .clk       (clk),
        .rst       (rst),
        .line_act  (line_act),
        .frame_act (frame_act),
        .nmi_en    (nmi_en),
        .halt_n    (halt_n),
        .flags     (flags)
    );

    assign hsync_n = ~flags.line_sync;
    assign vsync_n = ~flags.frame_sync;
    assign csync_n = ~flags.comp_sync;
    assign nmi_n   = ~flags.irq;
    assign wait_n  = ~flags.hold;

endmodule

// File: rtl/vsg_chk.sv
module vsg_chk #(
    parameter int CLK_DIV      = 2,
    parameter int HSYNC_CYCLES = 19
) (
    input logic clk,
    input logic rst,
    input logic halt_n,
    input logic cpu_clk,
    input logic hsync_n,
    input logic vsync_n,
    input logic csync_n,
    input logic nmi_n,
    input logic wait_n
);
    localparam int HS_MAX = HSYNC_CYCLES * CLK_DIV;

    logic [31:0] hs_run;
    always_ff @(posedge clk) begin
        if (rst)          hs_run <= '0;
        else if (hsync_n) hs_run <= '0;
        else              hs_run <= hs_run + 1;
    end

    // R4
    comp_sync_chk: assert property (@(posedge clk) disable iff (rst)
        csync_n == (hsync_n & vsync_n));

    // R5
    nmi_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |-> !hsync_n);

    // R6
    wait_rule_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wait_n == !(!nmi_n && $past(halt_n))));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (hsync_n && vsync_n && nmi_n && wait_n && !cpu_clk));

    // R9
    edge_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(hsync_n)) |-> !cpu_clk);

    // R2
    hs_width_chk: assert property (@(posedge clk) disable iff (rst)
        hs_run <= HS_MAX);

endmodule

bind video_sync_gen vsg_chk #(
    .CLK_DIV      (CLK_DIV),
    .HSYNC_CYCLES (HSYNC_CYCLES)
) u_chk (.*);

// File: tb/video_sync_gen_tb.sv
module video_sync_gen_tb;

    localparam int DIV   = 2;
    localparam int LINE  = 23;
    localparam int HS    = 5;
    localparam int LINES = 6;
    localparam int VS    = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_n = 1'b1;
    logic nmi_en = 1'b1;
    logic cpu_clk, hsync_n, vsync_n, csync_n, nmi_n, wait_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    video_sync_gen #(
        .CLK_DIV(DIV), .LINE_CYCLES(LINE), .HSYNC_CYCLES(HS),
        .FRAME_LINES(LINES), .VSYNC_CYCLES(VS)
    ) u_dut (
        .clk(clk), .rst(rst), .halt_n(halt_n), .nmi_en(nmi_en),
        .cpu_clk(cpu_clk), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .csync_n(csync_n), .nmi_n(nmi_n), .wait_n(wait_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: return cpu_clk;
            1: return hsync_n;
            2: return vsync_n;
            3: return csync_n;
            4: return nmi_n;
            default: return wait_n;
        endcase
    endfunction

    // Width of the low phase and fall-to-fall period, in dot clocks.
    task automatic measure(input int which, output int low_w, output int period);
        logic prev;
        logic cur;
        int   t;
        low_w  = -1;
        period = -1;
        @(negedge clk);
        prev = sig(which);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cur = sig(which);
            if (prev && !cur) break;
            prev = cur;
        end
        t = 0;
        prev = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            t++;
            cur = sig(which);
            if (low_w < 0 && cur) low_w = t;
            if (prev && !cur) begin
                period = t;
                break;
            end
            prev = cur;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        nmi_en = 1'b1;
        halt_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 idle hsync_n", hsync_n, 1);
        chk("R8 idle vsync_n", vsync_n, 1);
        chk("R8 idle nmi_n", nmi_n, 1);
        chk("R8 idle wait_n", wait_n, 1);
        chk("R8 idle cpu_clk", cpu_clk, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 first hsync_n", hsync_n, 0);
        chk("R8 first vsync_n", vsync_n, 0);
        chk("R8 first csync_n", csync_n, 0);
        chk("R8 first cpu_clk", cpu_clk, 0);
        @(negedge clk);
        chk("R8 cpu_clk rises", cpu_clk, 1);
    endtask

    task automatic t_cpu_clk;
        int w, p;
        measure(0, w, p);
        chk("R1 cpu_clk period", p, DIV);
        chk("R1 cpu_clk low part", w, DIV - DIV / 2);
    endtask

    task automatic t_line;
        int w, p;
        measure(1, w, p);
        chk("R2 hsync low width", w, HS * DIV);
        chk("R2 line period", p, LINE * DIV);
    endtask

    task automatic t_frame;
        int w, p;
        measure(2, w, p);
        chk("R3 vsync low width", w, VS * DIV);
        chk("R3 frame period", p, LINE * LINES * DIV);
        chk("R3 hsync low at frame start", hsync_n, 0);
    endtask

    task automatic t_csync;
        int w, p;
        measure(2, w, p);
        chk("R4 csync low at frame start", csync_n, 0);
        w = 0;
        while (!csync_n && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk("R4 csync merged width", w, VS * DIV);
        p = 0;
        while (csync_n && p < 500) begin
            @(negedge clk);
            p++;
        end
        chk("R4 gap to next line sync", p, 2 * LINE * DIV - VS * DIV);
        w = 0;
        while (!csync_n && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk("R4 csync line width", w, HS * DIV);
    endtask

    task automatic t_nmi_follow;
        int mism = 0;
        nmi_en = 1'b1;
        halt_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < LINE * DIV; i++) begin
            @(negedge clk);
            if (nmi_n != hsync_n) mism++;
            if (wait_n != nmi_n) mism++;
        end
        chk("R5 R6 nmi and wait track hsync", mism, 0);
    endtask

    task automatic t_nmi_off;
        int lows = 0;
        @(negedge clk);
        nmi_en = 1'b0;
        @(negedge clk);
        for (int i = 0; i < LINE * DIV; i++) begin
            @(negedge clk);
            if (!nmi_n || !wait_n) lows++;
        end
        chk("R5 nmi disabled stays high", lows, 0);
        nmi_en = 1'b1;
    endtask

    task automatic t_halted;
        int lows = 0;
        int nmis = 0;
        @(negedge clk);
        halt_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < LINE * DIV; i++) begin
            @(negedge clk);
            if (!wait_n) lows++;
            if (!nmi_n) nmis++;
        end
        chk("R7 wait held off while halted", lows, 0);
        chk("R7 nmi still pulses", nmis, HS * DIV);
        halt_n = 1'b1;
    endtask

    task automatic t_halt_mid;
        int guard = 0;
        halt_n = 1'b1;
        @(negedge clk);
        while (nmi_n && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk("R6 wait low in nmi", wait_n, 0);
        halt_n = 1'b0;
        @(negedge clk);
        chk("R6 wait released one clock after halt", wait_n, 1);
        chk("R6 nmi still low", nmi_n, 0);
        halt_n = 1'b1;
        @(negedge clk);
        chk("R6 wait reasserted one clock after run", wait_n, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_cpu_clk();
        t_line();
        t_frame();
        t_csync();
        t_nmi_follow();
        t_nmi_off();
        t_halted();
        t_halt_mid();
        t_reset();
        t_line();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule